// File: doc/BRIEF.md
# Microcoded Multi-Step Instruction Sequencer

This block is the control unit and datapath of a small multi-cycle processor. A microcode store produces one control word per clock, and each control word drives explicit register transfers. The block owns the instruction pointer, a memory address register, a memory data register, an instruction register, a temporary result register and an eight-entry, 32-bit register file. The block recognises two instructions: a register-to-register ADD and a no-op. Every other encoding stops the machine.

An instruction is handled in a fixed series of steps. The first fetch step copies the instruction pointer into the address register. A wait step covers the one-cycle read latency of the synchronous word-addressed memory. The next step captures the returned word in the data register, and the step after that moves it into the instruction register. In the decode step the sequencer dispatches on the opcode. For ADD, the execute step sums the two source registers into the temporary register. Writeback then stores that sum in the destination register and advances the instruction pointer by 4. Each register write is shown on a writeback port, and the current micro-address and the halt condition are output as well.

Top module: `ucs_top`

## Requirements
- R1: A synchronous reset sets the instruction pointer to 0, the micro-address to 0 and the halt flag to 0, and loads register k of the file with the value k.
- R2: In micro-step 1 the memory address output equals the instruction pointer of the current instruction. The memory is read synchronously, one cycle of latency, indexed by the address bits above bit 1.
- R3: The instruction word has opcode in [31:26], destination in [25:23], first source in [22:20] and second source in [19:17]. Bits [16:0] must be zero. ADD is opcode 0x01 and NOP is opcode 0x00.
- R4: ADD writes (r[src1] + r[src2]) mod 2^32 to r[dst]. This is the only register write of the instruction, and it is shown on the writeback port (enable, index, data) during the writeback step.
- R5: ADD walks the micro-addresses 0,1,2,3,4,5,6 and then returns to 0, taking seven cycles per instruction.
- R6: The instruction pointer rises by exactly 4 at the end of each completed ADD or NOP and is otherwise unchanged. The next fetch uses the new value.
- R7: NOP walks micro-addresses 0,1,2,3,4,7 and then returns to 0. It writes no register.
- R8: An opcode other than 0x00 or 0x01, or any nonzero bit in [16:0], moves the sequencer to micro-address 8 with the halt flag at 1. It stays there until reset, with the instruction pointer frozen and no register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | 32 | Byte address to memory (address register) |
| mem_rdata_i | input | 32 | Memory read word, one cycle after address |
| ip_o | output | 32 | Instruction pointer |
| upc_o | output | 4 | Current micro-address |
| halted_o | output | 1 | Sequencer is in the halt step |
| wb_en_o | output | 1 | Register file write this cycle |
| wb_dst_o | output | 3 | Register index being written |
| wb_data_o | output | 32 | Value being written |

## Verification
The main run executes an ADD for every one of the 512 combinations of destination, first source and second source. Because results feed later operands, aliasing between destination and sources is checked, and values grow until they wrap modulo 2^32. NOPs are placed at irregular points so that the sequence and pointer checks see both the six-step and seven-step paths back to back. A second short run after a fresh reset confirms the reseeded register contents. The last runs try every illegal opcode, and each reserved bit set alone in an otherwise valid ADD, to show that each of them halts and that the halt holds.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

  localparam int OPC_W = 6;
  localparam int UA_W  = 4;

  localparam logic [OPC_W-1:0] OPC_NOP = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADD = 6'h01;

  typedef enum logic [UA_W-1:0] {
    UA_F0   = 4'd0,
    UA_F1   = 4'd1,
    UA_F2   = 4'd2,
    UA_F3   = 4'd3,
    UA_DEC  = 4'd4,
    UA_EXE  = 4'd5,
    UA_WB   = 4'd6,
    UA_NOP  = 4'd7,
    UA_HALT = 4'd8
  } uaddr_e;

  // one control word: every enable that acts in a single cycle
  typedef struct packed {
    logic   ld_mar;
    logic   ld_mdr;
    logic   ld_ir;
    logic   ld_tmp;
    logic   rf_we;
    logic   ip_inc;
    logic   dispatch;
    uaddr_e next;
  } uword_t;

  // target of the opcode dispatch taken after decode
  function automatic uaddr_e dispatch_target(input logic [OPC_W-1:0] opc,
                                             input logic rsvd_clear);
    uaddr_e t;
    if (!rsvd_clear)         t = UA_HALT;
    else if (opc == OPC_ADD) t = UA_EXE;
    else if (opc == OPC_NOP) t = UA_NOP;
    else                     t = UA_HALT;
    return t;
  endfunction

endpackage

// File: rtl/ucs_rom.sv
module ucs_rom
  import ucs_pkg::*;
(
  input  uaddr_e upc,
  output uword_t cw
);

  always_comb begin
    cw      = '0;
    cw.next = UA_HALT;
    case (upc)
      UA_F0: begin
        cw.ld_mar = 1'b1;
        cw.next   = UA_F1;
      end
      UA_F1: begin
        cw.next = UA_F2;       // memory sees the address this cycle
      end
      UA_F2: begin
        cw.ld_mdr = 1'b1;
        cw.next   = UA_F3;
      end
      UA_F3: begin
        cw.ld_ir = 1'b1;
        cw.next  = UA_DEC;
      end
      UA_DEC: begin
        cw.dispatch = 1'b1;
        cw.next     = UA_HALT;  // overridden by dispatch
      end
      UA_EXE: begin
        cw.ld_tmp = 1'b1;
        cw.next   = UA_WB;
      end
      UA_WB: begin
        cw.rf_we  = 1'b1;
        cw.ip_inc = 1'b1;
        cw.next   = UA_F0;
      end
      UA_NOP: begin
        cw.ip_inc = 1'b1;
        cw.next   = UA_F0;
      end
      default: begin
        cw.next = UA_HALT;
      end
    endcase
  end

endmodule

// File: rtl/ucs_seq.sv
module ucs_seq
  import ucs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  uword_t           cw,
  input  logic [OPC_W-1:0] opc,
  input  logic             rsvd_clear,
  output uaddr_e           upc,
  output logic             dispatch_fire
);

  uaddr_e upc_d;

  assign dispatch_fire = cw.dispatch;

  always_comb begin
    if (cw.dispatch) upc_d = dispatch_target(opc, rsvd_clear);
    else             upc_d = cw.next;
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= UA_F0;
    else     upc <= upc_d;
  end

  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_F0) |=> (upc == UA_F1)); // R5

  AST_DISPATCH_ADD: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_DEC && opc == OPC_ADD && rsvd_clear) |=> (upc == UA_EXE)); // R3

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_HALT) |=> (upc == UA_HALT)); // R8

endmodule

// File: rtl/ucs_datapath.sv
module ucs_datapath
  import ucs_pkg::*;
#(
  parameter  int XLEN   = 32,
  parameter  int NREGS  = 8,
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  uword_t            cw,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [OPC_W-1:0]  opc,
  output logic              rsvd_clear,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   ip,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_dst,
  output logic [XLEN-1:0]   wb_data
);

  localparam int IP_STEP = XLEN / 8;
  localparam int DST_HI  = XLEN - OPC_W - 1;
  localparam int S1_HI   = DST_HI - RIDX_W;
  localparam int S2_HI   = S1_HI - RIDX_W;
  localparam int RSV_W   = XLEN - OPC_W - 3 * RIDX_W;

  function automatic logic [XLEN-1:0] f_add(input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [XLEN-1:0] f_ip_next(input logic [XLEN-1:0] p);
    return p + XLEN'(IP_STEP);
  endfunction

  logic [XLEN-1:0]   ip_q, mar_q, mdr_q, ir_q, tmp_q;
  logic [XLEN-1:0]   rf_q [NREGS];
  logic [RIDX_W-1:0] dst_idx, s1_idx, s2_idx;

  assign opc        = ir_q[XLEN-1 -: OPC_W];
  assign dst_idx    = ir_q[DST_HI -: RIDX_W];
  assign s1_idx     = ir_q[S1_HI -: RIDX_W];
  assign s2_idx     = ir_q[S2_HI -: RIDX_W];
  assign rsvd_clear = (ir_q[RSV_W-1:0] == '0);

  assign mem_addr = mar_q;
  assign ip       = ip_q;
  assign wb_en    = cw.rf_we;
  assign wb_dst   = dst_idx;
  assign wb_data  = tmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      tmp_q <= '0;
    end else begin
      if (cw.ld_mar) mar_q <= ip_q;
      if (cw.ld_mdr) mdr_q <= mem_rdata;
      if (cw.ld_ir)  ir_q  <= mdr_q;
      if (cw.ld_tmp) tmp_q <= f_add(rf_q[s1_idx], rf_q[s2_idx]);
      if (cw.ip_inc) ip_q  <= f_ip_next(ip_q);
    end
  end

  for (genvar k = 0; k < NREGS; k++) begin : g_rf
    always_ff @(posedge clk) begin
      if (rst)                             rf_q[k] <= XLEN'(k);
      else if (cw.rf_we && dst_idx == k)   rf_q[k] <= tmp_q;
    end
  end

  AST_MAR_FROM_IP: assert property (@(posedge clk) disable iff (rst)
    cw.ld_mar |=> (mar_q == $past(ip_q))); // R2

  AST_IP_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(ip_q) |-> (ip_q == $past(ip_q) + XLEN'(IP_STEP))); // R6

  AST_WB_ONLY_ADD: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (opc == OPC_ADD && rsvd_clear)); // R4

endmodule

// File: rtl/ucs_top.sv
module ucs_top
  import ucs_pkg::*;
#(
  parameter  int XLEN   = 32,
  parameter  int NREGS  = 8,
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   mem_addr_o,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic [XLEN-1:0]   ip_o,
  output logic [UA_W-1:0]   upc_o,
  output logic              halted_o,
  output logic              wb_en_o,
  output logic [RIDX_W-1:0] wb_dst_o,
  output logic [XLEN-1:0]   wb_data_o
);

  uaddr_e           upc;
  uword_t           cw;
  logic [OPC_W-1:0] opc;
  logic             rsvd_clear;
  logic             dispatch_fire;
  logic             in_halt;
  logic             in_nop;

  ucs_rom u_rom (
    .upc (upc),
    .cw  (cw)
  );

  ucs_seq u_seq (
    .clk           (clk),
    .rst           (rst),
    .cw            (cw),
    .opc           (opc),
    .rsvd_clear    (rsvd_clear),
    .upc           (upc),
    .dispatch_fire (dispatch_fire)
  );

  ucs_datapath #(.XLEN(XLEN), .NREGS(NREGS)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .cw         (cw),
    .mem_rdata  (mem_rdata_i),
    .opc        (opc),
    .rsvd_clear (rsvd_clear),
    .mem_addr   (mem_addr_o),
    .ip         (ip_o),
    .wb_en      (wb_en_o),
    .wb_dst     (wb_dst_o),
    .wb_data    (wb_data_o)
  );

  assign in_halt  = (upc == UA_HALT);
  assign in_nop   = (upc == UA_NOP);
  assign upc_o    = upc;
  assign halted_o = in_halt;

  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    in_halt |-> !wb_en_o); // R8

  AST_NOP_RETURNS: assert property (@(posedge clk) disable iff (rst)
    in_nop |=> (upc == UA_F0)); // R7

  AST_DISPATCH_AT_DECODE: assert property (@(posedge clk) disable iff (rst)
    dispatch_fire |-> $stable(ip_o)); // R6

endmodule

// File: tb/tb_ucs_top.sv
`timescale 1ns/1ps
module tb_ucs_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_rdata, ip, wb_data;
  logic [3:0]  upc;
  logic        halted, wb_en;
  logic [2:0]  wb_dst;

  always #2 clk = ~clk;

  ucs_top dut (
    .clk         (clk),
    .rst         (rst),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .ip_o        (ip),
    .upc_o       (upc),
    .halted_o    (halted),
    .wb_en_o     (wb_en),
    .wb_dst_o    (wb_dst),
    .wb_data_o   (wb_data)
  );

  logic [31:0] mem [0:1023];
  always @(posedge clk) mem_rdata <= mem[mem_addr[11:2]];

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int opc, input int d,
                                      input int a, input int b);
    return {opc[5:0], d[2:0], a[2:0], b[2:0], 17'd0};
  endfunction

  // instruction-level reference
  logic [31:0] mreg [8];
  logic [31:0] mpc, minstr, msum;
  int          exp_upc, cur_upc;
  bit          rst_seen = 0;

  always @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst) begin
      if (rst_seen) begin
        chk(ip == 32'd0, "R1", "reset ip", ip, 32'd0);
        chk(upc == 4'd0, "R1", "reset upc", {28'd0, upc}, 32'd0);
        chk(!halted, "R1", "reset halt", {31'd0, halted}, 32'd0);
      end
      for (int k = 0; k < 8; k++) mreg[k] = k;
      mpc = 0;
      exp_upc = 0;
    end else begin
      cur_upc = exp_upc;
      chk(upc == cur_upc[3:0], "R5", "micro-address", {28'd0, upc}, cur_upc);
      if (cur_upc != 6)
        chk(!wb_en, "R4", "stray write", {31'd0, wb_en}, 32'd0);
      case (cur_upc)
        0: begin
          chk(ip == mpc, "R6", "fetch pointer", ip, mpc);
          minstr  = mem[mpc[11:2]];
          exp_upc = 1;
        end
        1: begin
          chk(mem_addr == mpc, "R2", "fetch address", mem_addr, mpc);
          exp_upc = 2;
        end
        2: exp_upc = 3;
        3: exp_upc = 4;
        4: begin
          if (minstr[16:0] != 0)          exp_upc = 8;
          else if (minstr[31:26] == 6'd1) exp_upc = 5;
          else if (minstr[31:26] == 6'd0) exp_upc = 7;
          else                            exp_upc = 8;
        end
        5: exp_upc = 6;
        6: begin
          msum = mreg[minstr[22:20]] + mreg[minstr[19:17]];
          chk(wb_en, "R4", "write enable", {31'd0, wb_en}, 32'd1);
          chk(wb_dst == minstr[25:23], "R3", "dest index",
              {29'd0, wb_dst}, {29'd0, minstr[25:23]});
          chk(wb_data == msum, "R4", "sum", wb_data, msum);
          mreg[minstr[25:23]] = msum;
          mpc     = mpc + 4;
          exp_upc = 0;
        end
        7: begin
          chk(!wb_en, "R7", "nop write", {31'd0, wb_en}, 32'd0);
          mpc     = mpc + 4;
          exp_upc = 0;
        end
        default: begin
          chk(halted, "R8", "halt flag", {31'd0, halted}, 32'd1);
          chk(ip == mpc, "R8", "frozen pointer", ip, mpc);
        end
      endcase
    end
  end

  task automatic enter_reset();
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hFC00_0000;
  endtask

  task automatic leave_reset();
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "R5", "watchdog", cycles, 150000);
      summary();
    end
  end

  initial begin
    int j;
    // run 1: every dst/src1/src2 combination, NOPs interleaved (R3, R4, R5, R6, R7)
    enter_reset();
    j = 0;
    for (int i = 0; i < 512; i++) begin
      mem[j] = enc(1, i >> 6, (i >> 3) & 7, i & 7);
      j++;
      if (i % 37 == 0) begin
        mem[j] = enc(0, i & 7, 1, 2);
        j++;
      end
    end
    mem[j] = enc(6'h3F, 0, 0, 0);
    leave_reset();
    while (!halted) @(posedge clk);
    repeat (20) @(posedge clk);
    #1 chk(halted, "R8", "halt held", {31'd0, halted}, 32'd1);

    // run 2: reseeded registers after a fresh reset (R1)
    enter_reset();
    mem[0] = enc(1, 0, 3, 4);
    mem[1] = enc(0, 0, 0, 0);
    mem[2] = enc(1, 5, 5, 0);
    mem[3] = enc(6'h2A, 0, 0, 0);
    leave_reset();
    while (!halted) @(posedge clk);
    repeat (5) @(posedge clk);
    #1 chk(ip == 32'd12, "R1", "pointer after run 2", ip, 32'd12);

    // run 3: each illegal opcode halts (R8)
    for (int op = 2; op < 64; op++) begin
      enter_reset();
      mem[0] = enc(op, 1, 2, 3);
      leave_reset();
      repeat (12) @(posedge clk);
      #1 chk(halted, "R8", "illegal opcode", op, 32'd1);
    end

    // run 4: any reserved bit set in an ADD halts (R3, R8)
    for (int b = 0; b < 17; b++) begin
      enter_reset();
      mem[0] = enc(1, 1, 2, 3) | (32'd1 << b);
      leave_reset();
      repeat (12) @(posedge clk);
      #1 chk(halted && ip == 0, "R8", "reserved bit", b, 32'd0);
    end

    summary();
  end

endmodule